// File: doc/BRIEF.md
# Single-Step Shift Register with Micro-Operation Select

This block is a parameterised register that applies one single-position micro-operation each clock cycle in which its enable is high. A 3-bit operation code picks what happens: hold, parallel load, or a one-place shift. The shift can be logical, where the vacated end takes a serial-input bit. It can be circular, where the bit pushed out re-enters at the other end. It can be arithmetic, where the sign is kept on a right shift and overflow is reported on a left shift.

The current contents are driven out continuously. A one-bit overflow flag records whether the most recent enabled arithmetic left shift changed the sign bit.

The data pins are plain control-style inputs with no handshake. When the enable is high, the register accepts the word and the operation in that same cycle. It never applies back-pressure, and it never stalls the source.

Top module: `shift_uop_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `q` to all zeros and clears `ovf`. Reset takes priority over `en` and `op`.
- R2: When `en` is low, `q` and `ovf` both keep their values. With `en` high and `op` = 000 (hold), `q` keeps its value.
- R3: With `en` high and `op` = 001 (load), `q` takes `din` at the next edge.
- R4: With `en` high and `op` = 010 (logical left), every bit moves one place toward the MSB. `sin` enters bit 0 and the old MSB is discarded.
- R5: With `en` high and `op` = 011 (logical right), every bit moves one place toward bit 0. `sin` enters the MSB and the old bit 0 is discarded.
- R6: With `en` high and `op` = 100 (rotate left), the old MSB moves into bit 0 and the other bits move up one place.
- R7: With `en` high and `op` = 101 (rotate right), the old bit 0 moves into the MSB and the other bits move down one place.
- R8: With `en` high and `op` = 110 (arithmetic right), the MSB keeps its value and is also copied into bit WIDTH-2. The lower bits move down one place and the old bit 0 is discarded.
- R9: With `en` high and `op` = 111 (arithmetic left), a 0 enters bit 0 and the other bits move up one place. `ovf` becomes the XOR of bit WIDTH-1 and bit WIDTH-2 as they were before the shift.
- R10: Any enabled operation other than 111 clears `ovf`. This includes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable; the register changes only when high |
| op | input | 3 | Operation select (000 hold … 111 arithmetic left) |
| din | input | WIDTH | Parallel word used by the load operation |
| sin | input | 1 | Serial bit inserted by the logical shifts |
| q | output | WIDTH | Register contents |
| ovf | output | 1 | Sign-change flag from the last arithmetic left shift |

## Verification
The first corner case is the arithmetic left shift on each combination of the top two bits. A design that tested only the MSB, or that read the bits after the shift, would raise the overflow flag on the wrong words. The second is an arithmetic right shift of a negative value, such as 0x81. It shows whether the sign is replicated, since a design that filled the top with the serial bit or with zero would turn the value positive.

Rotations of 0x81 and 0x03 check that the bit leaving one end comes back at the other end, and logical shifts of 0x80 and 0x01 check that a bit pushed off the end is lost. The bench also holds a pending load with the enable low, sends a hold code after an overflow, and asserts reset together with a load. These three cases expose a flag that is cleared without the enable, a flag that sticks after the hold code, and a reset that loses to the load.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'b000,
    OP_LOAD = 3'b001,
    OP_SHL  = 3'b010,
    OP_SHR  = 3'b011,
    OP_ROL  = 3'b100,
    OP_ROR  = 3'b101,
    OP_ASR  = 3'b110,
    OP_ASL  = 3'b111
  } shop_e;
endpackage

// File: rtl/shreg_shifter.sv
// Next-value selector: one candidate per operation, chosen by the op code.
module shreg_shifter
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  input  logic             sin,
  input  shop_e            op,
  output logic [WIDTH-1:0] nxt
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    unique case (op)
      OP_HOLD: nxt = cur;
      OP_LOAD: nxt = din;
      OP_SHL:  nxt = {cur[MSB-1:0], sin};
      OP_SHR:  nxt = {sin, cur[MSB:1]};
      OP_ROL:  nxt = {cur[MSB-1:0], cur[MSB]};
      OP_ROR:  nxt = {cur[0], cur[MSB:1]};
      OP_ASR:  nxt = {cur[MSB], cur[MSB:1]};
      OP_ASL:  nxt = {cur[MSB-1:0], 1'b0};
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/shreg_ovf.sv
// Sign-change detector for the arithmetic left shift.
module shreg_ovf
  import shreg_pkg::*;
(
  input  shop_e op,
  input  logic  sign_bit,
  input  logic  next_bit,
  output logic  ovf_nxt
);
  always_comb begin
    ovf_nxt = (op == OP_ASL) ? (sign_bit ^ next_bit) : 1'b0;
  end
endmodule

// File: rtl/shift_uop_reg.sv
module shift_uop_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] din,
  input  logic             sin,
  output logic [WIDTH-1:0] q,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  shop_e            op_sel;
  logic [WIDTH-1:0] q_nxt;
  logic             ovf_nxt;

  assign op_sel = shop_e'(op);

  shreg_shifter #(.WIDTH(WIDTH)) u_shift (
    .cur (q),
    .din (din),
    .sin (sin),
    .op  (op_sel),
    .nxt (q_nxt)
  );

  shreg_ovf u_ovf (
    .op       (op_sel),
    .sign_bit (q[MSB]),
    .next_bit (q[MSB-1]),
    .ovf_nxt  (ovf_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      ovf <= 1'b0;
    end else if (en) begin
      q   <= q_nxt;
      ovf <= ovf_nxt;
    end
  end
endmodule

// File: rtl/shift_uop_reg_chk.sv
module shift_uop_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] din,
  input logic             sin,
  input logic [WIDTH-1:0] q,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0) && !ovf); // R1
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q) && $stable(ovf)); // R2
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b000) |=> $stable(q)); // R2
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b001) |=> q == $past(din)); // R3
  AST_SHL: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b010) |=> q == {$past(q[MSB-1:0]), $past(sin)}); // R4
  AST_SHR: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b011) |=> q == {$past(sin), $past(q[MSB:1])}); // R5
  AST_ROL: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b100) |=> q == {$past(q[MSB-1:0]), $past(q[MSB])}); // R6
  AST_ROR: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b101) |=> q == {$past(q[0]), $past(q[MSB:1])}); // R7
  AST_ASR: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b110) |=> q == {$past(q[MSB]), $past(q[MSB:1])}); // R8
  AST_ASL: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b111) |=> (q == {$past(q[MSB-1:0]), 1'b0})
                             && (ovf == ($past(q[MSB]) ^ $past(q[MSB-1])))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && op != 3'b111) |=> !ovf); // R10
endmodule

bind shift_uop_reg shift_uop_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk (clk),
  .rst (rst),
  .en  (en),
  .op  (op),
  .din (din),
  .sin (sin),
  .q   (q),
  .ovf (ovf)
);

// File: tb/tb_shift_uop_reg.sv
module tb_shift_uop_reg;
  localparam int W  = 8;
  localparam int NV = 23;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [2:0]   op  = 3'b000;
  logic [W-1:0] din = '0;
  logic         sin = 1'b0;
  logic [W-1:0] q;
  logic         ovf;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  shift_uop_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .en(en), .op(op),
    .din(din), .sin(sin), .q(q), .ovf(ovf)
  );

  // vector: {en, op, din, sin, expected q, expected ovf}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 3'd1, 8'hB4, 1'b0, 8'hB4, 1'b0}, // R3 load
    {1'b1, 3'd2, 8'h00, 1'b1, 8'h69, 1'b0}, // R4 shl, sin=1
    {1'b1, 3'd3, 8'h00, 1'b1, 8'hB4, 1'b0}, // R5 shr, sin=1
    {1'b1, 3'd4, 8'h00, 1'b0, 8'h69, 1'b0}, // R6 rotate left
    {1'b1, 3'd5, 8'h00, 1'b0, 8'hB4, 1'b0}, // R7 rotate right
    {1'b1, 3'd6, 8'h00, 1'b1, 8'hDA, 1'b0}, // R8 asr negative
    {1'b1, 3'd7, 8'h00, 1'b1, 8'hB4, 1'b0}, // R9 asl 11 -> no ovf
    {1'b1, 3'd7, 8'h00, 1'b0, 8'h68, 1'b1}, // R9 asl 10 -> ovf
    {1'b0, 3'd1, 8'hFF, 1'b1, 8'h68, 1'b1}, // R2 disabled load ignored
    {1'b1, 3'd0, 8'hFF, 1'b1, 8'h68, 1'b0}, // R2 R10 hold code clears ovf
    {1'b1, 3'd7, 8'h00, 1'b0, 8'hD0, 1'b1}, // R9 asl 01 -> ovf
    {1'b1, 3'd6, 8'h00, 1'b0, 8'hE8, 1'b0}, // R8 R10 asr clears ovf
    {1'b1, 3'd1, 8'h01, 1'b0, 8'h01, 1'b0}, // R3
    {1'b1, 3'd3, 8'h00, 1'b0, 8'h00, 1'b0}, // R5 LSB lost
    {1'b1, 3'd1, 8'h80, 1'b0, 8'h80, 1'b0}, // R3
    {1'b1, 3'd2, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 MSB lost
    {1'b1, 3'd1, 8'h81, 1'b0, 8'h81, 1'b0}, // R3
    {1'b1, 3'd4, 8'h00, 1'b0, 8'h03, 1'b0}, // R6 MSB wraps
    {1'b1, 3'd5, 8'h00, 1'b0, 8'h81, 1'b0}, // R7 LSB wraps
    {1'b1, 3'd6, 8'h00, 1'b0, 8'hC0, 1'b0}, // R8 sign copied
    {1'b1, 3'd1, 8'h40, 1'b1, 8'h40, 1'b0}, // R3
    {1'b1, 3'd6, 8'h00, 1'b1, 8'h20, 1'b0}, // R8 positive
    {1'b1, 3'd7, 8'h00, 1'b1, 8'h40, 1'b0}  // R9 asl 00 -> no ovf
  };

  task automatic check(input string req, input logic [W-1:0] eq, input logic eo);
    n_chk++;
    if (q !== eq || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: q=%h ovf=%b expected q=%h ovf=%b", req, q, ovf, eq, eo);
    end
  endtask

  task automatic step(input logic e, input logic [2:0] o, input logic [W-1:0] d, input logic s);
    en = e; op = o; din = d; sin = s;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", 8'h00, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:18], VEC[i][17:10], VEC[i][9]);
      check($sformatf("vector %0d (R2-R10)", i), VEC[i][8:1], VEC[i][0]);
    end
    // R9 overflow then R10 clear by load
    step(1'b1, 3'd1, 8'h7F, 1'b0);
    step(1'b1, 3'd7, 8'h00, 1'b0);
    check("R9 asl 0x7F", 8'hFE, 1'b1);
    step(1'b1, 3'd1, 8'h55, 1'b0);
    check("R10 load clears ovf", 8'h55, 1'b0);
    // R1 reset wins over an enabled load, and clears ovf
    step(1'b1, 3'd7, 8'h00, 1'b0);
    step(1'b1, 3'd7, 8'h00, 1'b0);
    check("R9 asl 0xAA", 8'h54, 1'b1);
    rst = 1'b1;
    step(1'b1, 3'd1, 8'hA5, 1'b1);
    check("R1 reset over load", 8'h00, 1'b0);
    rst = 1'b0;
    step(1'b0, 3'd1, 8'hA5, 1'b1);
    check("R2 disabled after reset", 8'h00, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule